// File: doc/BRIEF.md
# Three-Multiplier Pipelined Complex Multiplier

This block forms the product of two complex numbers, (a + jb) and (c + jd), using three real multiplications instead of four. One cross term, S = (a - b) * d, is computed once and added to both results. The real result is (c - d) * a + S and the imaginary result is (c + d) * b + S. All values are signed two's complement. The results are bit-exact against the direct form: real = ac - bd and imaginary = ad + bc.

The block is built as a four-register pipeline:

1. An input register.
2. A pre-add register: a - b, c - d and c + d, each one bit wider than its operands.
3. A product register.
4. A post-add register that drives the outputs.

The default operand widths are 26 bits for a and b and 17 bits for c and d. With these widths the pre-adder outputs are 27 and 18 bits wide, which matches a 27 x 18 hardware multiply slice that has its own pre-adder. The block accepts a new operand set on every clock. A valid strobe travels alongside the data so that each result is marked when it appears. There is no back-pressure, and there is no rounding or saturation. The outputs are wide enough that no overflow can occur.

Top module: `cmul3_core`

## Requirements
- R1: When `out_vld` is high, `out_re` equals a*c - b*d, computed exactly in the full output width, for the operand set that was sampled with it.
- R2: When `out_vld` is high, `out_im` equals a*d + b*c, computed exactly in the full output width, for the same operand set.
- R3: Every combination of operand values gives an exact result. This includes the most negative and most positive values, where both output words keep their top two bits equal.
- R4: An operand set sampled at a rising edge with `in_vld` high appears on the outputs just after the third rising edge that follows, with `out_vld` high. The latency is four registers.
- R5: A new operand set can be presented on every clock. A stream of back-to-back sets produces one result per clock, in the same order.
- R6: An edge where `in_vld` is low produces a cycle with `out_vld` low, three edges later. The operand values presented at that edge never appear as a valid result.
- R7: A rising edge with `rst_n` low clears the valid pipeline. After it, `out_vld` stays low until data sampled after the reset reaches the outputs, and sets that were in flight at the reset are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid pipeline only |
| in_vld | input | 1 | Operand set on op_a..op_d is valid this cycle |
| op_a | input | WA | Real part of the first factor, signed |
| op_b | input | WA | Imaginary part of the first factor, signed |
| op_c | input | WC | Real part of the second factor, signed |
| op_d | input | WC | Imaginary part of the second factor, signed |
| out_vld | output | 1 | Results on out_re/out_im are valid |
| out_re | output | WA+WC+2 | Real part of the product, signed |
| out_im | output | WA+WC+2 | Imaginary part of the product, signed |

## Verification
The properties compare each result with the direct formula applied to the operands sampled four edges earlier. They therefore assume that the operands are fully defined whenever `in_vld` is high, and that the reset is held for at least one rising edge before the first valid set. Only four consecutive edges without reset make the comparison meaningful, so a cycle counter in the checker suppresses it until that window has elapsed. The stimulus always drives defined values, including random values on bubble cycles. It keeps every operand inside its declared width, mixing extreme corners with random streams.

// File: rtl/cmul3_pkg.sv
// Package for the three-multiplier complex product unit.
// Holds the pre-adder mode type and the pipeline depth shared by the
// datapath, the valid pipeline and the checker.
package cmul3_pkg;

    // Selects whether a pre-adder adds or subtracts its second input.
    typedef enum logic {
        PRE_ADD = 1'b0,
        PRE_SUB = 1'b1
    } pre_mode_e;

    // Registers between operand sampling and result: input, pre-add,
    // product, post-add.
    localparam int unsigned PIPE_DEPTH = 4;

    // Full output width for operand widths wa and wc: a product of a
    // (wa+1)-bit and a wc-bit value, plus one bit for the post-add.
    function automatic int unsigned out_width(input int unsigned wa, input int unsigned wc);
        return wa + wc + 2;
    endfunction

endpackage

// File: rtl/cmul3_delay.sv
// Data-only delay line of DEPTH registers.
// Assumes DEPTH >= 1. The data registers carry no reset, because their
// contents only matter when the matching valid bit is set.
module cmul3_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the incoming word.
                always_ff @(posedge clk) begin
                    stage_q[g] <= din;
                end
            end else begin : g_next
                // Shift the word one stage further.
                always_ff @(posedge clk) begin
                    stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/cmul3_vld_pipe.sv
// Valid-bit shift register whose depth equals the datapath latency.
// Assumes DEPTH >= 1. The synchronous active-low reset clears every stage,
// so any set in flight at reset never reaches the output.
module cmul3_vld_pipe #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] vld_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Load the input strobe, or clear it on reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) vld_q[g] <= 1'b0;
                    else        vld_q[g] <= vin;
                end
            end else begin : g_next
                // Advance the strobe one stage, or clear it on reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) vld_q[g] <= 1'b0;
                    else        vld_q[g] <= vld_q[g-1];
                end
            end
        end
    endgenerate

    assign vout = vld_q[DEPTH-1];

endmodule

// File: rtl/cmul3_preadd.sv
// Registered signed pre-adder.
// Produces x + y or x - y, chosen by MODE, one bit wider than its
// inputs so that the result cannot wrap. Both inputs are IW bits wide.
module cmul3_preadd
    import cmul3_pkg::*;
#(
    parameter int unsigned IW   = 8,
    parameter pre_mode_e   MODE = PRE_ADD
) (
    input  logic                clk,
    input  logic signed [IW-1:0] x,
    input  logic signed [IW-1:0] y,
    output logic signed [IW:0]   z
);

    logic signed [IW:0] xe, ye;

    assign xe = {x[IW-1], x};
    assign ye = {y[IW-1], y};

    generate
        if (MODE == PRE_SUB) begin : g_sub
            // Register the difference.
            always_ff @(posedge clk) begin
                z <= xe - ye;
            end
        end else begin : g_add
            // Register the sum.
            always_ff @(posedge clk) begin
                z <= xe + ye;
            end
        end
    endgenerate

endmodule

// File: rtl/cmul3_mult.sv
// Registered signed multiplier with a full-width product.
// XW and YW are the operand widths; the product is XW+YW bits wide and
// is exact for every pair of operand values.
module cmul3_mult #(
    parameter int unsigned XW = 8,
    parameter int unsigned YW = 8
) (
    input  logic                      clk,
    input  logic signed [XW-1:0]      x,
    input  logic signed [YW-1:0]      y,
    output logic signed [XW+YW-1:0]   p
);

    localparam int unsigned PW = XW + YW;

    logic signed [PW-1:0] xe, ye;

    assign xe = {{YW{x[XW-1]}}, x};
    assign ye = {{XW{y[YW-1]}}, y};

    // Register the product.
    always_ff @(posedge clk) begin
        p <= xe * ye;
    end

endmodule

// File: rtl/cmul3_postadd.sv
// Registered signed post-adder.
// Adds two IW-bit signed values into an IW+1-bit result that cannot wrap.
module cmul3_postadd #(
    parameter int unsigned IW = 8
) (
    input  logic                 clk,
    input  logic signed [IW-1:0] x,
    input  logic signed [IW-1:0] y,
    output logic signed [IW:0]   s
);

    logic signed [IW:0] xe, ye;

    assign xe = {x[IW-1], x};
    assign ye = {y[IW-1], y};

    // Register the sum.
    always_ff @(posedge clk) begin
        s <= xe + ye;
    end

endmodule

// File: rtl/cmul3_core.sv
// Three-multiplier pipelined complex multiplier.
// Computes (a + jb)(c + jd) as
//   S  = (a - b) * d
//   re = (c - d) * a + S
//   im = (c + d) * b + S
// in four register stages: input, pre-add, multiply and post-add.
// Assumptions:
//   - Operands are signed two's complement. a and b are WA bits wide,
//     c and d are WC bits wide.
//   - With the defaults, each multiply is 27 x 18 bits wide.
//   - A new operand set may arrive every clock, and there is no stall.
//   - Only the valid pipeline is reset; data registers hold don't-care
//     values until valid data reaches them.
module cmul3_core
    import cmul3_pkg::*;
#(
    parameter int unsigned WA = 26,
    parameter int unsigned WC = 17
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic signed [WA-1:0]       op_a,
    input  logic signed [WA-1:0]       op_b,
    input  logic signed [WC-1:0]       op_c,
    input  logic signed [WC-1:0]       op_d,
    output logic                       out_vld,
    output logic signed [WA+WC+1:0]    out_re,
    output logic signed [WA+WC+1:0]    out_im
);

    localparam int unsigned PA_W = WA + 1;          // width of a - b
    localparam int unsigned PC_W = WC + 1;          // width of c +/- d
    localparam int unsigned PR_W = WA + WC + 1;     // width of each product
    localparam int unsigned OW   = out_width(WA, WC);

    // Stage 1: registered operands.
    logic signed [WA-1:0] a1, b1;
    logic signed [WC-1:0] c1, d1;

    // Stage 2: pre-adder results and operands aligned with them.
    logic signed [PA_W-1:0] ab_dif2;
    logic signed [PC_W-1:0] cd_dif2, cd_sum2;
    logic signed [WA-1:0]   a2, b2;
    logic signed [WC-1:0]   d2;

    // Stage 3: products.
    logic signed [PR_W-1:0] shr3, pre3, pim3;

    // Stage 4: results.
    logic signed [OW-1:0]   re4, im4;

    // Input register for all four operands.
    cmul3_delay #(.W(2*WA + 2*WC), .DEPTH(1)) i_in_reg (
        .clk  (clk),
        .din  ({op_a, op_b, op_c, op_d}),
        .dout ({a1, b1, c1, d1})
    );

    // Delay a, b and d by one more stage to meet the pre-adder outputs.
    cmul3_delay #(.W(2*WA + WC), .DEPTH(1)) i_align_reg (
        .clk  (clk),
        .din  ({a1, b1, d1}),
        .dout ({a2, b2, d2})
    );

    // Pre-adders: a - b, c - d, c + d.
    cmul3_preadd #(.IW(WA), .MODE(PRE_SUB)) i_pre_ab (
        .clk (clk), .x (a1), .y (b1), .z (ab_dif2)
    );
    cmul3_preadd #(.IW(WC), .MODE(PRE_SUB)) i_pre_cd_dif (
        .clk (clk), .x (c1), .y (d1), .z (cd_dif2)
    );
    cmul3_preadd #(.IW(WC), .MODE(PRE_ADD)) i_pre_cd_sum (
        .clk (clk), .x (c1), .y (d1), .z (cd_sum2)
    );

    // Multipliers: the shared term and the two part-specific products.
    cmul3_mult #(.XW(PA_W), .YW(WC)) i_mul_shared (
        .clk (clk), .x (ab_dif2), .y (d2), .p (shr3)
    );
    cmul3_mult #(.XW(WA), .YW(PC_W)) i_mul_re (
        .clk (clk), .x (a2), .y (cd_dif2), .p (pre3)
    );
    cmul3_mult #(.XW(WA), .YW(PC_W)) i_mul_im (
        .clk (clk), .x (b2), .y (cd_sum2), .p (pim3)
    );

    // Post-adders: the shared term added into both parts.
    cmul3_postadd #(.IW(PR_W)) i_post_re (
        .clk (clk), .x (pre3), .y (shr3), .s (re4)
    );
    cmul3_postadd #(.IW(PR_W)) i_post_im (
        .clk (clk), .x (pim3), .y (shr3), .s (im4)
    );

    // Valid strobe that travels alongside the data.
    cmul3_vld_pipe #(.DEPTH(PIPE_DEPTH)) i_vld (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_vld),
        .vout  (out_vld)
    );

    assign out_re = re4;
    assign out_im = im4;

endmodule

// File: rtl/cmul3_chk.sv
// Property checker for cmul3_core, attached with bind.
// Compares each valid result with the direct four-multiply formula
// applied to the operands seen PIPE_DEPTH edges earlier. A counter of
// edges since reset keeps every check inside the window since reset.
module cmul3_chk
    import cmul3_pkg::*;
#(
    parameter int unsigned WA = 26,
    parameter int unsigned WC = 17
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_vld,
    input logic signed [WA-1:0]     op_a,
    input logic signed [WA-1:0]     op_b,
    input logic signed [WC-1:0]     op_c,
    input logic signed [WC-1:0]     op_d,
    input logic                     out_vld,
    input logic signed [WA+WC+1:0]  out_re,
    input logic signed [WA+WC+1:0]  out_im
);

    localparam int unsigned OW = WA + WC + 2;

    logic signed [OW-1:0] ea, eb, ec, ed, dir_re, dir_im;
    logic [2:0]           since_rst;

    assign ea = {{(OW-WA){op_a[WA-1]}}, op_a};
    assign eb = {{(OW-WA){op_b[WA-1]}}, op_b};
    assign ec = {{(OW-WC){op_c[WC-1]}}, op_c};
    assign ed = {{(OW-WC){op_d[WC-1]}}, op_d};
    assign dir_re = ea * ec - eb * ed;
    assign dir_im = ea * ed + eb * ec;

    // Count edges since the last reset edge, saturating at the depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                      since_rst <= '0;
        else if (since_rst < 3'(PIPE_DEPTH)) since_rst <= since_rst + 3'd1;
    end

    // R4, R5, R6: the output strobe follows the input strobe four edges later.
    p_vld_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(PIPE_DEPTH)) |-> (out_vld == $past(in_vld, 4)));

    // R1: the real part matches the direct formula.
    p_real_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(PIPE_DEPTH) && out_vld) |-> (out_re == $past(dir_re, 4)));

    // R2: the imaginary part matches the direct formula.
    p_imag_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(PIPE_DEPTH) && out_vld) |-> (out_im == $past(dir_im, 4)));

    // R3: results never reach the two top bits of the output word.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_re[OW-1] == out_re[OW-2] && out_im[OW-1] == out_im[OW-2]));

    // R7: no valid output until post-reset data has crossed the pipeline.
    p_reset_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'(PIPE_DEPTH)) |-> !out_vld);

endmodule

bind cmul3_core cmul3_chk #(.WA(WA), .WC(WC)) i_cmul3_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_c    (op_c),
    .op_d    (op_d),
    .out_vld (out_vld),
    .out_re  (out_re),
    .out_im  (out_im)
);

// File: tb/test_cmul3_core.sv
// Bench for cmul3_core: a behavioural queue model compared every clock.
module test_cmul3_core;

    localparam int WA = 26;
    localparam int WC = 17;
    localparam int OW = WA + WC + 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_vld = 1'b0;
    logic signed [WA-1:0]   op_a = '0, op_b = '0;
    logic signed [WC-1:0]   op_c = '0, op_d = '0;
    logic                   out_vld;
    logic signed [OW-1:0]   out_re, out_im;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit     v;
        longint re;
        longint im;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    cmul3_core #(.WA(WA), .WC(WC)) i_cmul3_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .op_a    (op_a),
        .op_b    (op_b),
        .op_c    (op_c),
        .op_d    (op_d),
        .out_vld (out_vld),
        .out_re  (out_re),
        .out_im  (out_im)
    );

    localparam longint AMAX = (64'sd1 <<< (WA-1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (WA-1));
    localparam longint CMAX = (64'sd1 <<< (WC-1)) - 1;
    localparam longint CMIN = -(64'sd1 <<< (WC-1));

    task automatic check(input string tag, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic cyc(input string tag, input bit rst, input bit v,
                       input longint a, input longint b, input longint c, input longint d);
        exp_t e;
        rst_n  = !rst;
        in_vld = v;
        op_a   = a[WA-1:0];
        op_b   = b[WA-1:0];
        op_c   = c[WC-1:0];
        op_d   = d[WC-1:0];
        @(posedge clk);
        if (rst) begin
            foreach (q[i]) q[i].v = 1'b0;
            e.v = 1'b0; e.re = 0; e.im = 0;
        end else begin
            e.v  = v;
            e.re = a * c - b * d;
            e.im = a * d + b * c;
        end
        q.push_back(e);
        @(negedge clk);
        if (q.size() == 4) begin
            e = q.pop_front();
            check({tag, " valid"}, out_vld == e.v, longint'(out_vld), longint'(e.v));
            if (e.v) begin
                check({tag, " real (R1)"}, longint'(out_re) == e.re, longint'(out_re), e.re);
                check({tag, " imag (R2)"}, longint'(out_im) == e.im, longint'(out_im), e.im);
            end
        end
    endtask

    function automatic longint rnd_a();
        return longint'($signed(26'($urandom)));
    endfunction

    function automatic longint rnd_c();
        return longint'($signed(17'($urandom)));
    endfunction

    initial begin
        @(negedge clk);
        // R7: reset state.
        cyc("R7 reset", 1, 1, 5, 6, 7, 8);
        cyc("R7 reset", 1, 1, 5, 6, 7, 8);
        check("R7 out_vld in reset", out_vld == 1'b0, longint'(out_vld), 0);
        cyc("R7 reset", 1, 0, 0, 0, 0, 0);

        // R4: single set; valid appears exactly three edges after sampling.
        cyc("R4 idle", 0, 0, 1, 1, 1, 1);
        cyc("R4 single", 0, 1, 3, -2, 5, 7);
        check("R4 +0", out_vld == 1'b0, longint'(out_vld), 0);
        cyc("R4 idle", 0, 0, 9, 9, 9, 9);
        check("R4 +1", out_vld == 1'b0, longint'(out_vld), 0);
        cyc("R4 idle", 0, 0, 9, 9, 9, 9);
        check("R4 +2", out_vld == 1'b0, longint'(out_vld), 0);
        cyc("R4 idle", 0, 0, 9, 9, 9, 9);
        check("R4 +3", out_vld == 1'b1, longint'(out_vld), 1);
        check("R4 real", longint'(out_re) == 3*5 - (-2)*7, longint'(out_re), 29);
        check("R4 imag", longint'(out_im) == 3*7 + (-2)*5, longint'(out_im), 11);

        // R3: extreme corners, back to back.
        cyc("R3", 0, 1, AMIN, AMIN, CMIN, CMIN);
        cyc("R3", 0, 1, AMIN, AMAX, CMIN, CMAX);
        cyc("R3", 0, 1, AMAX, AMIN, CMAX, CMIN);
        cyc("R3", 0, 1, AMAX, AMAX, CMAX, CMAX);
        cyc("R3", 0, 1, AMIN, AMIN, CMAX, CMIN);
        cyc("R3", 0, 1, AMIN, AMAX, CMAX, CMIN);
        cyc("R3", 0, 1, 0, AMIN, 0, CMIN);
        cyc("R3", 0, 1, AMIN, 0, CMIN, 0);
        cyc("R3", 0, 1, -1, -1, -1, -1);

        // R5: long back-to-back random stream.
        for (int i = 0; i < 400; i++)
            cyc("R5 stream", 0, 1, rnd_a(), rnd_a(), rnd_c(), rnd_c());

        // R6: random bubbles with random data on idle edges.
        for (int i = 0; i < 400; i++)
            cyc("R6 bubbles", 0, 1'($urandom), rnd_a(), rnd_a(), rnd_c(), rnd_c());

        // R7: reset in the middle of a stream drops in-flight sets.
        for (int i = 0; i < 3; i++)
            cyc("R7 pre", 0, 1, rnd_a(), rnd_a(), rnd_c(), rnd_c());
        cyc("R7 mid reset", 1, 1, rnd_a(), rnd_a(), rnd_c(), rnd_c());
        for (int i = 0; i < 6; i++)
            cyc("R7 after", 0, (i >= 2), rnd_a(), rnd_a(), rnd_c(), rnd_c());

        for (int i = 0; i < 6; i++)
            cyc("R1 drain", 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule